// File: doc/BRIEF.md
# I2C Register Burst-Read Controller

This block is a single-command I2C controller that fetches a run of consecutive registers from one target device. The host presents a 7-bit target address, an 8-bit register index and a byte count, then pulses `start_i` for one clock. The controller first points the target at the register index in a write frame. It then turns the bus around with a repeated START, addresses the target for reading, and collects the requested number of bytes. Each byte is presented on `rdata_o` with a one-cycle `rvalid_o` strobe. The bus pins are open-drain enables: driving an enable high pulls that line low, and the SDA level is read back on `sda_in_i`.

Bus timing comes from a quarter-phase timer. Every bit slot lasts four quarters of `QTR_CLKS` system clocks. SCL is low in quarters 3 and 0 and high in quarters 1 and 2. SDA is changed at the 3→0 boundary, in the middle of SCL low, and is sampled at the 1→2 boundary, in the middle of SCL high. The control is one state machine with these states: IDLE, START, WADDR, WADDR_ACK, WREG, WREG_ACK, RSTART, RADDR, RADDR_ACK, RDATA, MACK and STOP. Its transitions are:

- IDLE→START on an accepted start pulse, and START→WADDR.
- WADDR→WADDR_ACK, WREG→WREG_ACK, RADDR→RADDR_ACK and RDATA→MACK, each after eight bits.
- WADDR_ACK→WREG, WREG_ACK→RSTART and RADDR_ACK→RDATA when the target acknowledges.
- Any target-ACK state goes to STOP when the target does not acknowledge.
- RSTART→RADDR.
- MACK→RDATA while bytes remain, and MACK→STOP after the last byte.
- STOP→IDLE.

Top module: `i2c_burst_reader`

## Requirements
- R1: After reset, and again once each command has finished, both line enables are low (lines released) and `busy_o` is low.
- R2: A command produces, in order: START, the target address with direction write, the register index, a repeated START with no STOP before it, the target address with direction read, the data bytes, and one STOP at the end.
- R3: SDA changes while SCL is high only to form a START, a repeated START or a STOP. A good command therefore shows exactly three such changes.
- R4: Every byte is sent and received most significant bit first. In an address byte, bits 7:1 carry the target address and bit 0 is the direction (0 = write, 1 = read).
- R5: The controller drives ACK (SDA low) after every received byte except the last, drives NACK (SDA released) after the last, and then sends STOP. A count of 0 is handled as a count of 1.
- R6: Each received byte appears on `rdata_o` together with a one-cycle `rvalid_o` pulse after its eighth bit is sampled. Exactly the requested number of bytes is delivered.
- R7: If SDA reads high in the ACK slot after the write address or after the register index, the controller sets `err_o`, sends STOP, pulses `done_o` and delivers no bytes.
- R8: `done_o` is a single-cycle pulse at the end of every command. `err_o` stays set until the next accepted start, which clears it.
- R9: A start pulse that arrives while `busy_o` is high is ignored, and the running command completes with its original parameters.
- R10: During a command, SCL rises once every 4*`QTR_CLKS` clocks and stays high for 2*`QTR_CLKS` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle command start, taken only when idle |
| dev_addr_i | input | 7 | Target device address |
| reg_idx_i | input | 8 | First register index to read |
| nbytes_i | input | CNT_W | Number of bytes to read (0 reads one) |
| sda_in_i | input | 1 | Sampled level of the SDA line |
| scl_pull_o | output | 1 | High pulls SCL low |
| sda_pull_o | output | 1 | High pulls SDA low |
| rdata_o | output | 8 | Last received byte |
| rvalid_o | output | 1 | One-cycle strobe marking a new `rdata_o` |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a command |
| err_o | output | 1 | Target did not acknowledge, held until next start |

## Verification
The assertions assume that `sda_in_i` is a settled, synchronous copy of the wired-AND bus. They also assume that no other device moves SCL, since a stretched clock would break the fixed quarter timing that the SDA-quiet property relies on. The bench meets both assumptions. Its target model drives SDA only right after an SCL falling edge and never touches SCL. The DUT samples in the middle of SCL high, many clocks away from any SDA change.

// File: rtl/i2c_brd_pkg.sv
package i2c_brd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WREG,
        ST_WREG_ACK,
        ST_RSTART,
        ST_RADDR,
        ST_RADDR_ACK,
        ST_RDATA,
        ST_MACK,
        ST_STOP
    } brd_state_e;

    // states in which the controller shifts a byte out on SDA
    function automatic logic is_tx_byte(brd_state_e s);
        return (s == ST_WADDR) || (s == ST_WREG) || (s == ST_RADDR);
    endfunction

    // states in which the target owns the ACK slot
    function automatic logic is_tgt_ack(brd_state_e s);
        return (s == ST_WADDR_ACK) || (s == ST_WREG_ACK) || (s == ST_RADDR_ACK);
    endfunction

    // any eight-bit data slot, either direction
    function automatic logic is_byte(brd_state_e s);
        return is_tx_byte(s) || (s == ST_RDATA);
    endfunction

    // bus conditions that move SDA while SCL is high
    function automatic logic is_cond(brd_state_e s);
        return (s == ST_START) || (s == ST_RSTART) || (s == ST_STOP);
    endfunction

endpackage

// File: rtl/i2c_brd_qtimer.sv
module i2c_brd_qtimer #(
    parameter int QTR_CLKS = 62
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);

    localparam int CW = (QTR_CLKS > 1) ? $clog2(QTR_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CLKS - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    generate
        if (QTR_CLKS > 1) begin : g_gap_chk
            // R10: quarter ticks are never back to back
            p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o)
                else $error("quarter ticks adjacent");
        end
    endgenerate

endmodule

// File: rtl/i2c_brd_shift.sv
module i2c_brd_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] data_o
);

    logic [W-1:0] sh_q;

    assign data_o = sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= load_val_i;
        end else if (shift_i) begin
            sh_q <= {sh_q[W-2:0], bit_i};
        end
    end

endmodule

// File: rtl/i2c_burst_reader.sv
module i2c_burst_reader
    import i2c_brd_pkg::*;
#(
    parameter int QTR_CLKS = 62,
    parameter int CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [6:0]       dev_addr_i,
    input  logic [7:0]       reg_idx_i,
    input  logic [CNT_W-1:0] nbytes_i,
    input  logic             sda_in_i,
    output logic             scl_pull_o,
    output logic             sda_pull_o,
    output logic [7:0]       rdata_o,
    output logic             rvalid_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);

    localparam logic [CNT_W-1:0] ONE_BYTE = CNT_W'(1);
    localparam logic [1:0]       Q_SAMPLE = 2'd1;
    localparam logic [1:0]       Q_LAST   = 2'd3;

    brd_state_e       state_q, state_d;
    logic [1:0]       q_q;
    logic [2:0]       bit_q;
    logic [CNT_W-1:0] left_q;
    logic [6:0]       addr_q;
    logic [7:0]       reg_q;
    logic             ack_ok_q, err_q, done_q, rvalid_q;
    logic [7:0]       rdata_q;

    logic             tick, slot_end, sample_pt, accept;
    logic             sh_load, sh_shift;
    logic [7:0]       sh_val, sh_data;
    logic             low_ph, more_left;

    assign slot_end  = tick && (q_q == Q_LAST);
    assign sample_pt = tick && (q_q == Q_SAMPLE);
    assign accept    = (state_q == ST_IDLE) && start_i;
    assign low_ph    = (q_q == 2'd0) || (q_q == 2'd3);
    assign more_left = left_q > ONE_BYTE;

    i2c_brd_qtimer #(.QTR_CLKS(QTR_CLKS)) u_qtimer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q != ST_IDLE),
        .tick_o (tick)
    );

    i2c_brd_shift #(.W(8)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (sh_load),
        .load_val_i (sh_val),
        .shift_i    (sh_shift),
        .bit_i      (sda_in_i),
        .data_o     (sh_data)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_START;
            ST_START:     if (slot_end) state_d = ST_WADDR;
            ST_WADDR:     if (slot_end && bit_q == 3'd7) state_d = ST_WADDR_ACK;
            ST_WADDR_ACK: if (slot_end) state_d = ack_ok_q ? ST_WREG : ST_STOP;
            ST_WREG:      if (slot_end && bit_q == 3'd7) state_d = ST_WREG_ACK;
            ST_WREG_ACK:  if (slot_end) state_d = ack_ok_q ? ST_RSTART : ST_STOP;
            ST_RSTART:    if (slot_end) state_d = ST_RADDR;
            ST_RADDR:     if (slot_end && bit_q == 3'd7) state_d = ST_RADDR_ACK;
            ST_RADDR_ACK: if (slot_end) state_d = ack_ok_q ? ST_RDATA : ST_STOP;
            ST_RDATA:     if (slot_end && bit_q == 3'd7) state_d = ST_MACK;
            ST_MACK:      if (slot_end) state_d = more_left ? ST_RDATA : ST_STOP;
            ST_STOP:      if (slot_end) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // shifter control: load on entry to a transmit byte, shift per slot or sample
    always_comb begin
        sh_load  = (state_d != state_q) && is_tx_byte(state_d);
        sh_shift = (slot_end && is_tx_byte(state_q)) ||
                   (sample_pt && state_q == ST_RDATA);
        unique case (state_d)
            ST_WADDR: sh_val = {addr_q, 1'b0};
            ST_WREG:  sh_val = reg_q;
            ST_RADDR: sh_val = {addr_q, 1'b1};
            default:  sh_val = '0;
        endcase
    end

    // state register and sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            q_q      <= '0;
            bit_q    <= '0;
            left_q   <= '0;
            addr_q   <= '0;
            reg_q    <= '0;
            ack_ok_q <= 1'b0;
            err_q    <= 1'b0;
            done_q   <= 1'b0;
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            state_q  <= state_d;
            done_q   <= slot_end && (state_q == ST_STOP);
            rvalid_q <= sample_pt && (state_q == ST_RDATA) && (bit_q == 3'd7);

            if (state_q == ST_IDLE) begin
                q_q <= '0;
            end else if (tick) begin
                q_q <= q_q + 2'd1;
            end

            if (slot_end) begin
                bit_q <= is_byte(state_q) ? bit_q + 3'd1 : 3'd0;
            end

            if (accept) begin
                addr_q <= dev_addr_i;
                reg_q  <= reg_idx_i;
                left_q <= (nbytes_i == '0) ? ONE_BYTE : nbytes_i;
                err_q  <= 1'b0;
            end else if (slot_end && state_q == ST_MACK) begin
                left_q <= left_q - ONE_BYTE;
            end

            if (sample_pt && is_tgt_ack(state_q)) begin
                ack_ok_q <= !sda_in_i;
            end

            if (slot_end && is_tgt_ack(state_q) && !ack_ok_q) begin
                err_q <= 1'b1;
            end

            if (sample_pt && state_q == ST_RDATA && bit_q == 3'd7) begin
                rdata_q <= {sh_data[6:0], sda_in_i};
            end
        end
    end

    // line drive per state and quarter
    always_comb begin
        scl_pull_o = 1'b0;
        sda_pull_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                scl_pull_o = 1'b0;
                sda_pull_o = 1'b0;
            end
            ST_START: begin
                scl_pull_o = (q_q == 2'd3);
                sda_pull_o = q_q[1];
            end
            ST_RSTART: begin
                scl_pull_o = low_ph;
                sda_pull_o = q_q[1];
            end
            ST_STOP: begin
                scl_pull_o = (q_q == 2'd0);
                sda_pull_o = !q_q[1];
            end
            ST_WADDR, ST_WREG, ST_RADDR: begin
                scl_pull_o = low_ph;
                sda_pull_o = !sh_data[7];
            end
            ST_WADDR_ACK, ST_WREG_ACK, ST_RADDR_ACK, ST_RDATA: begin
                scl_pull_o = low_ph;
                sda_pull_o = 1'b0;
            end
            ST_MACK: begin
                scl_pull_o = low_ph;
                sda_pull_o = more_left;
            end
            default: begin
                scl_pull_o = 1'b0;
                sda_pull_o = 1'b0;
            end
        endcase
    end

    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;
    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = done_q;
    assign err_o    = err_q;

    // R3: SDA holds while SCL stays high outside START, repeated START and STOP
    p_sda_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_pull_o && $past(!scl_pull_o) && !is_cond(state_q) && !is_cond($past(state_q)))
        |-> $stable(sda_pull_o))
        else $error("SDA moved while SCL high");

    // R1: at the end of a command both lines are released and the block is idle
    p_idle_after_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!scl_pull_o && !sda_pull_o && !busy_o))
        else $error("lines not released at done");

    // R6: the byte strobe lasts one cycle
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |=> !rvalid_o)
        else $error("rvalid longer than one cycle");

    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("done longer than one cycle");

    // R8: the error flag holds until a start is accepted
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !(start_i && !busy_o)) |=> err_o)
        else $error("error flag dropped");

    // R7: no byte is delivered after an abort
    p_no_data_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !rvalid_o)
        else $error("byte delivered after abort");

    // R9: command parameters hold while busy
    p_cmd_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(addr_q) && $stable(reg_q)))
        else $error("command changed while busy");

endmodule

// File: tb/i2c_burst_reader_tb.sv
`timescale 1ns/1ps
module i2c_burst_reader_tb;

    localparam int         QTR = 5;
    localparam logic [6:0] TGT = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [6:0] addr = '0;
    logic [7:0] idx = '0;
    logic [7:0] cnt = '0;
    logic       scl_pull, sda_pull, rvalid, busy, done, err;
    logic [7:0] rdata;
    logic       tgt_pull = 1'b0;
    logic       nack_reg = 1'b0;

    wire scl_line = ~scl_pull;
    wire sda_line = ~(sda_pull | tgt_pull);

    always #5 clk = ~clk;

    i2c_burst_reader #(.QTR_CLKS(QTR), .CNT_W(8)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .dev_addr_i (addr),
        .reg_idx_i  (idx),
        .nbytes_i   (cnt),
        .sda_in_i   (sda_line),
        .scl_pull_o (scl_pull),
        .sda_pull_o (sda_pull),
        .rdata_o    (rdata),
        .rvalid_o   (rvalid),
        .busy_o     (busy),
        .done_o     (done),
        .err_o      (err)
    );

    function automatic logic [7:0] tgt_byte(input logic [7:0] p);
        return p * 8'd13 + 8'h5A;
    endfunction

    // ---------------- target model (register file device) ----------------
    int         t_mode = 0;  // 0 idle, 1 rx addr, 2 rx index, 3 rx other, 4 tx, 5 wait stop
    int         t_fbit = 0;
    logic [7:0] t_sh = '0, t_txb = '0, t_ptr = '0, seen_reg = '0;
    bit         t_ack = 0, t_rw = 0, t_lastack = 0, prev_scl = 1, prev_sda = 1;
    int         n_start = 0, n_stop = 0, n_aw = 0, n_ar = 0, n_mack = 0, n_mnack = 0;

    always @(scl_line or sda_line) begin
        if (scl_line && prev_scl && prev_sda && !sda_line) begin
            n_start++;
            t_mode = 1; t_fbit = 0; tgt_pull = 1'b0;
        end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
            n_stop++;
            t_mode = 0; tgt_pull = 1'b0;
        end else if (scl_line && !prev_scl) begin
            if (t_mode >= 1 && t_mode <= 4) begin
                if (t_fbit < 8) begin
                    if (t_mode != 4) t_sh = {t_sh[6:0], sda_line};
                end else if (t_mode == 4) begin
                    t_lastack = !sda_line;
                    if (!sda_line) n_mack++; else n_mnack++;
                end
                t_fbit++;
            end
        end else if (!scl_line && prev_scl) begin
            if (t_mode >= 1 && t_mode <= 4) begin
                if (t_fbit == 8) begin
                    t_ack = 0;
                    if (t_mode == 1 && t_sh[7:1] == TGT) begin
                        t_ack = 1; tgt_pull = 1'b1; t_rw = t_sh[0];
                        if (t_sh[0]) n_ar++; else n_aw++;
                    end else if (t_mode == 2 && !nack_reg) begin
                        t_ack = 1; tgt_pull = 1'b1; t_ptr = t_sh; seen_reg = t_sh;
                    end else if (t_mode == 4) begin
                        tgt_pull = 1'b0;
                    end
                end else if (t_fbit == 9) begin
                    tgt_pull = 1'b0; t_fbit = 0;
                    if (t_mode == 1) begin
                        if (!t_ack) t_mode = 0;
                        else if (t_rw) begin
                            t_mode = 4; t_txb = tgt_byte(t_ptr); t_ptr++; tgt_pull = ~t_txb[7];
                        end else t_mode = 2;
                    end else if (t_mode == 2) begin
                        t_mode = t_ack ? 3 : 0;
                    end else if (t_mode == 4) begin
                        if (t_lastack) begin
                            t_txb = tgt_byte(t_ptr); t_ptr++; tgt_pull = ~t_txb[7];
                        end else t_mode = 5;
                    end
                end else if (t_mode == 4 && t_fbit >= 1 && t_fbit <= 7) begin
                    tgt_pull = ~t_txb[7 - t_fbit];
                end
            end
        end
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    // ---------------- output monitor ----------------
    int         cyc = 0, nget = 0, n_done = 0, n_hichg = 0;
    int         last_rise = 0, prev_rise = 0, hi_len = 0;
    logic [7:0] got [0:63];
    bit         m_scl = 1, m_sda = 1;

    always @(negedge clk) begin
        cyc++;
        if (rvalid && nget < 64) begin
            got[nget] = rdata;
            nget++;
        end
        if (done) n_done++;
        if (scl_line && m_scl && (sda_line != m_sda)) n_hichg++;
        if (scl_line && !m_scl) begin
            prev_rise = last_rise;
            last_rise = cyc;
        end
        if (!scl_line && m_scl) hi_len = cyc - last_rise;
        m_scl = scl_line;
        m_sda = sda_line;
    end

    // ---------------- checking helpers ----------------
    int n_chk = 0, n_fail = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [6:0] a, input logic [7:0] r, input logic [7:0] n);
        @(negedge clk); #1;
        addr = a; idx = r; cnt = n; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done();
        int b = n_done;
        for (int i = 0; i < 40000 && n_done == b; i++) begin
            @(negedge clk); #1;
        end
        if (n_done == b) chk("watchdog", "command never finished", 0, 1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "scl pull after reset", int'(scl_pull), 0);
        chk("R1", "sda pull after reset", int'(sda_pull), 0);
        chk("R8", "done after reset", int'(done), 0);
        chk("R8", "err after reset", int'(err), 0);
    endtask

    task automatic t_burst(input logic [7:0] r, input logic [7:0] n);
        int b_get = nget, b_st = n_start, b_sp = n_stop, b_aw = n_aw, b_ar = n_ar;
        int b_ma = n_mack, b_mn = n_mnack, b_dn = n_done, b_hc = n_hichg;
        int exp_n = (n == 0) ? 1 : int'(n);
        send(TGT, r, n);
        wait_done();
        chk("R1", "busy at done", int'(busy), 0);
        chk("R1", "scl pull at done", int'(scl_pull), 0);
        chk("R1", "sda pull at done", int'(sda_pull), 0);
        repeat (4) @(negedge clk);
        #1;
        chk("R6", "bytes delivered", nget - b_get, exp_n);
        for (int i = 0; i < exp_n; i++)
            chk("R4", "byte value", int'(got[b_get + i]), int'(tgt_byte(r + 8'(i))));
        chk("R2", "START count", n_start - b_st, 2);
        chk("R2", "STOP count", n_stop - b_sp, 1);
        chk("R2", "write address frames", n_aw - b_aw, 1);
        chk("R2", "read address frames", n_ar - b_ar, 1);
        chk("R4", "index seen by target", int'(seen_reg), int'(r));
        chk("R3", "SDA edges during SCL high", n_hichg - b_hc, 3);
        chk("R5", "master ACKs", n_mack - b_ma, exp_n - 1);
        chk("R5", "master NACKs", n_mnack - b_mn, 1);
        chk("R8", "done pulses", n_done - b_dn, 1);
        chk("R8", "err after good command", int'(err), 0);
        chk("R10", "SCL period", last_rise - prev_rise, 4 * QTR);
        chk("R10", "SCL high time", hi_len, 2 * QTR);
    endtask

    task automatic t_nack_addr();
        int b_get = nget, b_st = n_start, b_sp = n_stop, b_dn = n_done;
        send(7'h33, 8'h10, 8'd4);
        wait_done();
        chk("R7", "err on address NACK", int'(err), 1);
        chk("R1", "lines released after abort", int'(scl_pull | sda_pull), 0);
        repeat (30) @(negedge clk);
        #1;
        chk("R7", "bytes after address NACK", nget - b_get, 0);
        chk("R7", "START count on abort", n_start - b_st, 1);
        chk("R7", "STOP count on abort", n_stop - b_sp, 1);
        chk("R8", "done pulses on abort", n_done - b_dn, 1);
        chk("R8", "err still held while idle", int'(err), 1);
    endtask

    task automatic t_nack_reg();
        int b_get = nget, b_st = n_start, b_sp = n_stop, b_aw = n_aw;
        nack_reg = 1'b1;
        send(TGT, 8'h44, 8'd3);
        wait_done();
        nack_reg = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        chk("R7", "err on index NACK", int'(err), 1);
        chk("R7", "bytes after index NACK", nget - b_get, 0);
        chk("R7", "write address acked", n_aw - b_aw, 1);
        chk("R7", "START count on index abort", n_start - b_st, 1);
        chk("R7", "STOP count on index abort", n_stop - b_sp, 1);
    endtask

    task automatic t_busy_ignore();
        int b_get = nget, b_st = n_start, b_dn = n_done;
        send(TGT, 8'h20, 8'd3);
        repeat (100) @(negedge clk);
        #1;
        chk("R9", "busy mid command", int'(busy), 1);
        addr = 7'h11; idx = 8'h40; cnt = 8'd5; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        wait_done();
        repeat (40) @(negedge clk);
        #1;
        chk("R9", "bytes with ignored start", nget - b_get, 3);
        chk("R9", "first byte from original index", int'(got[b_get]), int'(tgt_byte(8'h20)));
        chk("R9", "index seen by target", int'(seen_reg), 32'h20);
        chk("R9", "START count", n_start - b_st, 2);
        chk("R9", "single done", n_done - b_dn, 1);
        chk("R9", "idle after", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        t_burst(8'h10, 8'd6);     // R5 default six-byte burst
        t_burst(8'hF0, 8'd1);     // R5 single byte: NACK only
        t_burst(8'h07, 8'd0);     // R5 count 0 read as one
        t_nack_addr();            // R7
        t_burst(8'h33, 8'd2);     // R8 error cleared by next start
        t_nack_reg();             // R7
        t_busy_ignore();          // R9
        t_burst(8'hFE, 8'd4);     // R4 index wraps past 0xFF
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule